// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and the calendar in packed BCD. A tick input pulsing once every tenth of a second advances a tenths digit. That digit carries into seconds, then minutes, hours, date, month and a two-digit year. A day-of-week counter steps together with the date. The last date of each month follows the month length. February is extended to 29 days whenever the year value is a multiple of four.

An access controller changes any of the eight registers through a one-cycle load port, addressed by a 3-bit index. Bits that a register does not use are dropped on the way in, so they always read back as zero. The single exception is the stored 24-hour mode flag in bit 7 of the hours register. Any load into a time or calendar register restarts the tenths digit, so the following second lasts a full period. All eight registers are presented as parallel outputs, for read-back and for alarm comparison.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the date and month read 01h. The tenths, seconds, minutes, hours, year and day-of-week registers read 00h.
- R2: Each cycle with tick_i high and wr_en_i low advances the tenths digit (bits 3:0, 0 to 9). A tick at 9 returns the digit to 0 and advances the seconds.
- R3: Seconds and minutes count in BCD from 00 to 59 and carry one digit into the next. From 59 they return to 00 and advance the next field. Bit 7 of both always reads 0.
- R4: Hours count in BCD from 00 to 23 in bits 5:0. After 23 they return to 00 and advance the date. Bit 7 is a stored 24-hour mode flag that counting leaves untouched. Bit 6 reads 0.
- R5: The date (bits 5:0) returns to 01 and advances the month after the last date of the month. That last date is 30 for months 04h, 06h, 09h and 11h, and 31 for months 01h, 03h, 05h, 07h, 08h, 10h and 12h.
- R6: The last date of month 02h is 29 when the year value (00 to 99) is divisible by 4, year 00 included, and 28 otherwise.
- R7: The month (bits 4:0) returns from 12 to 01 and advances the year. The year (a full byte) returns from 99 to 00.
- R8: The day of week (bits 2:0, 0 to 6) advances in the same cycle as the date, and returns from 6 to 0.
- R9: When wr_en_i is high, the register chosen by wr_addr_i takes wr_data_i at the clock edge. The address codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 tenths. Unused bits are dropped: bit 7 for seconds and minutes, bit 6 for hours, bits 7:6 for the date, bits 7:5 for the month, bits 7:3 for the day of week and bits 7:4 for the tenths.
- R10: A load to addresses 0 to 6 clears the tenths digit to 0. Counting ignores a tick in the same cycle as any load. Registers not addressed keep their values.
- R11: A load to address 7 sets the tenths digit, and counting continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every tenth of a second |
| wr_en_i | input | 1 | Load strobe |
| wr_addr_i | input | 3 | Register index for the load |
| wr_data_i | input | 8 | Load value |
| tenths_o | output | 8 | Tenths digit |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Mode flag and hours, BCD |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| dow_o | output | 8 | Day of week |

## Verification
The collision that matters is a load and a tenths tick in the same cycle. The bench provokes it by raising tick_i and wr_en_i together while the tenths digit sits mid-count. It then confirms that the minutes take the new value, the tenths read 0 and the seconds do not move. A further nine ticks must leave the seconds unchanged, and the tenth tick must advance them. A second collision sits inside the carry chain: a single tick can wrap every field from tenths to year in one cycle. That case is judged by reading all eight outputs at the next falling edge after that tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS);
  localparam int unsigned DATA_W   = 8;

  localparam int unsigned A_SEC  = 0;
  localparam int unsigned A_MIN  = 1;
  localparam int unsigned A_HOUR = 2;
  localparam int unsigned A_DATE = 3;
  localparam int unsigned A_MON  = 4;
  localparam int unsigned A_YEAR = 5;
  localparam int unsigned A_DOW  = 6;
  localparam int unsigned A_TEN  = 7;

  // bits kept on a load
  function automatic logic [DATA_W-1:0] wr_mask(int unsigned idx);
    case (idx)
      A_SEC, A_MIN: return 8'h7F;
      A_HOUR:       return 8'hBF;
      A_DATE:       return 8'h3F;
      A_MON:        return 8'h1F;
      A_YEAR:       return 8'hFF;
      A_DOW:        return 8'h07;
      default:      return 8'h0F;
    endcase
  endfunction

  // bits that take part in counting; the rest are kept as flags
  function automatic logic [DATA_W-1:0] cnt_mask(int unsigned idx);
    return (idx == A_HOUR) ? 8'h3F : wr_mask(idx);
  endfunction

  function automatic logic [DATA_W-1:0] low_val(int unsigned idx);
    return (idx == A_DATE || idx == A_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [DATA_W-1:0] rst_val(int unsigned idx);
    return low_val(idx);
  endfunction

  function automatic logic [DATA_W-1:0] top_val(int unsigned idx);
    case (idx)
      A_SEC, A_MIN: return 8'h59;
      A_HOUR:       return 8'h23;
      A_DATE:       return 8'h31;
      A_MON:        return 8'h12;
      A_YEAR:       return 8'h99;
      A_DOW:        return 8'h06;
      default:      return 8'h09;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] bcd_inc(logic [DATA_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(logic [DATA_W-1:0] y);
    logic [7:0] bin;
    bin = {4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] month_last(logic [DATA_W-1:0] m, logic leap);
    case (m)
      8'h02:                     return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL  = 8'h00,
  parameter logic [DATA_W-1:0] LO_VAL   = 8'h00,
  parameter logic [DATA_W-1:0] WR_MASK  = 8'hFF,
  parameter logic [DATA_W-1:0] CNT_MASK = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [DATA_W-1:0] max_i,
  output logic [DATA_W-1:0] val_o,
  output logic              at_max_o
);
  logic [DATA_W-1:0] val_q, val_d, cnt, flags;

  assign cnt      = val_q & CNT_MASK;
  assign flags    = val_q & ~CNT_MASK;
  assign at_max_o = (cnt == max_i);

  always_comb begin
    val_d = val_q;
    if (ld_i)       val_d = ld_data_i & WR_MASK;
    else if (clr_i) val_d = LO_VAL | flags;
    else if (inc_i) val_d = (at_max_o ? LO_VAL : (bcd_inc(cnt) & CNT_MASK)) | flags;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= RST_VAL;
    else         val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/rtc_month_end.sv
module rtc_month_end
  import rtc_cal_pkg::*;
(
  input  logic [DATA_W-1:0] month_i,
  input  logic [DATA_W-1:0] year_i,
  output logic [DATA_W-1:0] last_o
);
  logic leap;
  assign leap   = leap_year(year_i);
  assign last_o = month_last(month_i, leap);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] tenths_o,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] hour_o,
  output logic [DATA_W-1:0] date_o,
  output logic [DATA_W-1:0] month_o,
  output logic [DATA_W-1:0] year_o,
  output logic [DATA_W-1:0] dow_o
);
  logic [DATA_W-1:0] val    [NUM_REGS];
  logic [DATA_W-1:0] max_v  [NUM_REGS];
  logic              at_max [NUM_REGS];
  logic              inc    [NUM_REGS];
  logic [DATA_W-1:0] date_last;
  logic              ten_clr;

  rtc_month_end u_month_end (
    .month_i (val[A_MON]),
    .year_i  (val[A_YEAR]),
    .last_o  (date_last)
  );

  // loads anywhere but the tenths restart the second
  assign ten_clr = wr_en_i && (wr_addr_i != ADDR_W'(A_TEN));

  // carry chain from state only, no combinational loop
  always_comb begin
    inc[A_TEN]  = tick_i && !wr_en_i;
    inc[A_SEC]  = inc[A_TEN]  && at_max[A_TEN];
    inc[A_MIN]  = inc[A_SEC]  && at_max[A_SEC];
    inc[A_HOUR] = inc[A_MIN]  && at_max[A_MIN];
    inc[A_DATE] = inc[A_HOUR] && at_max[A_HOUR];
    inc[A_DOW]  = inc[A_DATE];
    inc[A_MON]  = inc[A_DATE] && at_max[A_DATE];
    inc[A_YEAR] = inc[A_MON]  && at_max[A_MON];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_field
    if (i == A_DATE) begin : g_dyn
      assign max_v[i] = date_last;
    end else begin : g_fix
      assign max_v[i] = top_val(i);
    end

    rtc_bcd_field #(
      .RST_VAL  (rst_val(i)),
      .LO_VAL   (low_val(i)),
      .WR_MASK  (wr_mask(i)),
      .CNT_MASK (cnt_mask(i))
    ) u_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (wr_en_i && (wr_addr_i == ADDR_W'(i))),
      .ld_data_i (wr_data_i),
      .clr_i     ((i == A_TEN) ? ten_clr : 1'b0),
      .inc_i     (inc[i]),
      .max_i     (max_v[i]),
      .val_o     (val[i]),
      .at_max_o  (at_max[i])
    );
  end

  assign tenths_o = val[A_TEN];
  assign sec_o    = val[A_SEC];
  assign min_o    = val[A_MIN];
  assign hour_o   = val[A_HOUR];
  assign date_o   = val[A_DATE];
  assign month_o  = val[A_MON];
  assign year_o   = val[A_YEAR];
  assign dow_o    = val[A_DOW];
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
  import rtc_cal_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] tenths_o,
  input logic [DATA_W-1:0] sec_o,
  input logic [DATA_W-1:0] min_o,
  input logic [DATA_W-1:0] hour_o,
  input logic [DATA_W-1:0] date_o,
  input logic [DATA_W-1:0] month_o,
  input logic [DATA_W-1:0] year_o,
  input logic [DATA_W-1:0] dow_o
);
  p_tenths_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && tenths_o < 8'h09) |=> (tenths_o == $past(tenths_o) + 8'd1));

  p_sec_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !(tick_i && tenths_o == 8'h09)) |=> $stable(sec_o));

  p_sec_bit7_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o[7] == 1'b0) && (min_o[7] == 1'b0));

  p_flag_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (hour_o[7] == $past(hour_o[7])));

  p_dow_with_date_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(dow_o) == $stable(date_o)));

  p_load_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != ADDR_W'(A_TEN)) |=> (tenths_o == 8'h00));

  p_year_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != ADDR_W'(A_YEAR)) |=> $stable(year_o));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (.*);

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i, wr_en_i;
  logic [2:0] wr_addr_i;
  logic [7:0] wr_data_i;
  logic [7:0] tenths_o, sec_o, min_o, hour_o, date_o, month_o, year_o, dow_o;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #4 clk_i = ~clk_i;

  rtc_calendar_core dut_i (.*);

  // {addr, data, expected read-back}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 8'hD9, 8'h59}, {3'd1, 8'hC5, 8'h45}, {3'd2, 8'hFF, 8'hBF},
    {3'd2, 8'h63, 8'h23}, {3'd3, 8'hF1, 8'h31}, {3'd4, 8'hE9, 8'h09},
    {3'd5, 8'h87, 8'h87}, {3'd6, 8'hFD, 8'h05}, {3'd7, 8'hA4, 8'h04},
    {3'd0, 8'h00, 8'h00}
  };

  function automatic logic [7:0] rd(input logic [2:0] a);
    case (a)
      3'd0: return sec_o;
      3'd1: return min_o;
      3'd2: return hour_o;
      3'd3: return date_o;
      3'd4: return month_o;
      3'd5: return year_o;
      3'd6: return dow_o;
      default: return tenths_o;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [2:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk_i);
    wr_en_i = wr; wr_addr_i = a; wr_data_i = d; tick_i = tk;
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 3'd0, 8'h00, 1'b1);
  endtask

  task automatic ld(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dt, mo, y, dw);
    ld(3'd0, s); ld(3'd1, m); ld(3'd2, h); ld(3'd3, dt);
    ld(3'd4, mo); ld(3'd5, y); ld(3'd6, dw);
  endtask

  // run from 23:59:59.0 across midnight
  task automatic midnight(input logic [7:0] dt, mo, y, input logic [7:0] edt, emo, input string req);
    set_time(8'h59, 8'h59, 8'h23, dt, mo, y, 8'h01);
    ticks(10);
    chk(req, date_o, edt);
    chk(req, month_o, emo);
  endtask

  initial begin
    rst_ni = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 8; a++)
      chk("R1", rd(3'(a)), (a == 3 || a == 4) ? 8'h01 : 8'h00);
    rst_ni = 1'b1;

    // R9 load masks
    for (int v = 0; v < NV; v++) begin
      ld(VEC[v][18:16], VEC[v][15:8]);
      chk("R9", rd(VEC[v][18:16]), VEC[v][7:0]);
    end

    // R2 tenths counting
    ld(3'd0, 8'h00);
    ticks(3);
    chk("R2", tenths_o, 8'h03);
    ticks(6);
    chk("R2", tenths_o, 8'h09);
    chk("R2", sec_o, 8'h00);
    ticks(1);
    chk("R2", tenths_o, 8'h00);
    chk("R2", sec_o, 8'h01);

    // R3 digit carry into minutes
    ld(3'd0, 8'h59); ld(3'd1, 8'h09);
    ticks(10);
    chk("R3", sec_o, 8'h00);
    chk("R3", min_o, 8'h10);

    // full wrap of every field in one tick
    set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06);
    ticks(9);
    chk("R3", sec_o, 8'h59);
    ticks(1);
    chk("R3", sec_o, 8'h00);
    chk("R3", min_o, 8'h00);
    chk("R4", hour_o, 8'h80);
    chk("R5", date_o, 8'h01);
    chk("R7", month_o, 8'h01);
    chk("R7", year_o, 8'h00);
    chk("R8", dow_o, 8'h00);

    // R8 day of week steps with date
    set_time(8'h59, 8'h59, 8'h23, 8'h10, 8'h03, 8'h50, 8'h02);
    ticks(10);
    chk("R8", dow_o, 8'h03);
    chk("R8", date_o, 8'h11);

    // R5 month lengths
    midnight(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, "R5");
    midnight(8'h30, 8'h11, 8'h21, 8'h01, 8'h12, "R5");
    midnight(8'h30, 8'h01, 8'h21, 8'h31, 8'h01, "R5");
    midnight(8'h30, 8'h09, 8'h21, 8'h01, 8'h10, "R5");

    // R6 February
    midnight(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R6");
    midnight(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R6");
    midnight(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R6");
    midnight(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R6");
    midnight(8'h28, 8'h02, 8'h10, 8'h01, 8'h03, "R6");
    midnight(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, "R6");

    // R10 load and tick in the same cycle
    set_time(8'h10, 8'h20, 8'h05, 8'h15, 8'h06, 8'h30, 8'h02);
    ticks(5);
    cyc(1'b1, 3'd1, 8'h21, 1'b1);
    chk("R10", tenths_o, 8'h00);
    chk("R10", min_o, 8'h21);
    chk("R10", sec_o, 8'h10);
    chk("R10", year_o, 8'h30);
    ticks(9);
    chk("R10", sec_o, 8'h10);
    ticks(1);
    chk("R10", sec_o, 8'h11);

    // R11 tenths load
    ld(3'd7, 8'hF7);
    chk("R11", tenths_o, 8'h07);
    chk("R11", sec_o, 8'h11);
    ticks(2);
    chk("R11", tenths_o, 8'h09);
    ticks(1);
    chk("R11", sec_o, 8'h12);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule